// File: doc/BRIEF.md
# Bridge-Capable PWM Generator with Dead-Time Insertion

This block produces pulse-width-modulated drive for up to four switches from one shared timebase. A period value and a duty value set the waveform. Both are sampled into shadow registers only when a period ends, so a change never cuts a pulse short or stretches it.

A mode input selects how the four outputs, A to D, are driven. In single mode only A switches. In dual mode A and B form a complementary pair with a programmable dead time. In quad mode one switch of a full bridge is held on while one switch of the other leg is modulated, and a direction input picks the diagonal. Each output can be made active-low. In quad mode the inversion is set per pair instead.

A typical use is motor or converter drive. Software programs the period and duty, picks the dead time in units of four clocks, and selects the mode and polarity to suit its gate drivers.

Top module: `pwm_bridge_gen`

## Requirements
- R1: While rst_n is low at a clock edge, the shadow period and duty registers, the timebase counter and the dead-time counter clear. With mode 0 and pol_n = 0 all four outputs are then low.
- R2: Mode 0 (single) drives A active for exactly duty clock cycles in every period of period clock cycles. B, C and D stay at their inactive level. A period value of 0 or 1 gives a one-cycle period.
- R3: Mode 1 (dual) drives B as the complement of A, and the two are never active in the same cycle.
- R4: In dual mode, after every edge of the underlying waveform, the output about to turn on waits 4*dead_in clock cycles while both outputs are inactive.
- R5: In dual mode, a high or low phase no longer than 4*dead_in cycles never turns its output on.
- R6: A duty of 0 keeps the modulated output inactive. A duty equal to or above the period keeps it active for the whole period, and in dual mode its complement stays inactive.
- R7: A new period_in or duty_in value is used only from the start of the next period. A pulse already in progress keeps its old width, and the rest of that period keeps its old length.
- R8: Mode 2 (quad) with fwd_dir = 1 holds A active and modulates D with the duty; B and C are inactive. With fwd_dir = 0 it holds C active and modulates B; A and D are inactive.
- R9: pol_n bit i set makes output i active-low (bit 0 is A, bit 3 is D) in modes 0, 1 and 3. In mode 2, pol_n bit 0 sets the polarity of both A and C, and pol_n bit 1 sets the polarity of both B and D.
- R10: Mode 3 holds all four outputs at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | 0 single, 1 dual, 2 quad, 3 all outputs off |
| fwd_dir | input | 1 | Quad diagonal: 1 = A held and D modulated, 0 = C held and B modulated |
| pol_n | input | 4 | Per-output active-low selects (used pairwise in quad mode) |
| period_in | input | PER_W | Period length in clock cycles, taken at the period boundary |
| duty_in | input | PER_W | Active cycles per period, taken at the period boundary |
| dead_in | input | DEAD_W | Dead time in units of four clock cycles |
| pwm_out | output | 4 | Output levels, bit 0 = A through bit 3 = D |

## Verification
The bench measures active-cycle counts per output over whole periods, then checks them against the following corner cases:
- Dead time eats into each phase. A design that shortened only one edge would show the wrong count on one output of the pair.
- A pulse shorter than the dead time. A design that did not restart the counter on every edge would let a sliver through.
- A duty of zero and a duty at or above the period, where an off-by-one compare leaks a cycle.
- The quad diagonals under pairwise polarity. A wrong pol_n bit mapping would invert C or D.

Directed tests measure the exact dead gap on both edges. They also change duty and period in the middle of a pulse; a design that loaded its shadow registers immediately would cut that pulse short.

// File: rtl/pwm_bridge_pkg.sv
// Shared types for the bridge PWM generator.
// Assumes mode encodings are fixed by software convention.
package pwm_bridge_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_DUAL   = 2'd1,
        MODE_QUAD   = 2'd2,
        MODE_OFF    = 2'd3
    } pwm_mode_e;

    localparam int NUM_OUT = 4;
endpackage

// File: rtl/pwm_timebase.sv
// Period counter with shadowed period and duty.
// The raw waveform is high while the count is below the shadow duty.
// Assumes a period of 0 or 1 means a one-cycle period.
module pwm_timebase #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_in,
    input  logic [PER_W-1:0] duty_in,
    output logic             raw,
    output logic [PER_W-1:0] cnt,
    output logic [PER_W-1:0] per_sh,
    output logic [PER_W-1:0] duty_sh
);
    localparam int EXT_W = PER_W + 1;

    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] duty_q;
    logic             wrap;

    // Last count of the period reached (or a degenerate period is loaded).
    assign wrap = (EXT_W'(cnt_q) + EXT_W'(1)) >= EXT_W'(per_q);

    // Advance the count; reload the count and the shadows at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            per_q  <= '0;
            duty_q <= '0;
        end else if (wrap) begin
            cnt_q  <= '0;
            per_q  <= period_in;
            duty_q <= duty_in;
        end else begin
            cnt_q  <= cnt_q + PER_W'(1);
        end
    end

    assign raw     = cnt_q < duty_q;
    assign cnt     = cnt_q;
    assign per_sh  = per_q;
    assign duty_sh = duty_q;
endmodule

// File: rtl/pwm_deadband.sv
// Complementary pair generator with dead time.
// The wait counter reloads on every edge of the raw waveform, and a side
// turns on only once the counter has drained. A plain one-cycle delayed
// copy of the raw waveform is also provided.
// Assumes the dead time is given in units of four clocks.
module pwm_deadband #(
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw,
    input  logic [DEAD_W-1:0] dead_steps,
    output logic              lag,
    output logic              on_hi,
    output logic              on_lo
);
    localparam int CW = DEAD_W + 2;

    logic [CW-1:0] dt;
    logic [CW-1:0] wait_q;
    logic [CW-1:0] wait_nxt;
    logic          raw_q;
    logic          flip;

    assign dt   = {dead_steps, 2'b00};
    assign flip = raw ^ raw_q;

    // Next wait count: reload on an edge, otherwise drain toward zero.
    always_comb begin
        if (flip) begin
            wait_nxt = dt;
        end else if (wait_q != '0) begin
            wait_nxt = wait_q - CW'(1);
        end else begin
            wait_nxt = '0;
        end
    end

    // Register the delayed waveform and the wait count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= 1'b0;
            wait_q <= '0;
        end else begin
            raw_q  <= raw;
            wait_q <= wait_nxt;
        end
    end

    assign lag   = raw_q;
    assign on_hi = raw_q & (wait_q == '0);
    assign on_lo = ~raw_q & (wait_q == '0);
endmodule

// File: rtl/pwm_steer.sv
// Maps the modulated signals onto outputs A..D according to the mode
// and applies output polarity.
// Assumes pol_n bits invert per output, pairwise in quad mode.
module pwm_steer
    import pwm_bridge_pkg::*;
(
    input  pwm_mode_e            mode,
    input  logic                 fwd,
    input  logic [NUM_OUT-1:0]   pol_n,
    input  logic                 mod,
    input  logic                 on_hi,
    input  logic                 on_lo,
    output logic [NUM_OUT-1:0]   out
);
    logic [NUM_OUT-1:0] act;
    logic [NUM_OUT-1:0] pol_eff;

    // Choose which outputs are active and the polarity each one uses.
    always_comb begin
        act     = '0;
        pol_eff = pol_n;
        case (mode)
            MODE_SINGLE: act[0] = mod;
            MODE_DUAL: begin
                act[0] = on_hi;
                act[1] = on_lo;
            end
            MODE_QUAD: begin
                pol_eff = {pol_n[1], pol_n[0], pol_n[1], pol_n[0]};
                if (fwd) begin
                    act[0] = 1'b1;
                    act[3] = mod;
                end else begin
                    act[2] = 1'b1;
                    act[1] = mod;
                end
            end
            default: act = '0;
        endcase
        out = act ^ pol_eff;
    end
endmodule

// File: rtl/pwm_bridge_gen.sv
// Top of the bridge PWM generator: timebase, dead-time pair and steering.
// Assumes mode, direction and polarity may change at any time and act at
// once, while period and duty act from the next period.
module pwm_bridge_gen
    import pwm_bridge_pkg::*;
#(
    parameter int PER_W  = 8,
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              fwd_dir,
    input  logic [3:0]        pol_n,
    input  logic [PER_W-1:0]  period_in,
    input  logic [PER_W-1:0]  duty_in,
    input  logic [DEAD_W-1:0] dead_in,
    output logic [3:0]        pwm_out
);
    logic             raw;
    logic             lag;
    logic             on_hi;
    logic             on_lo;
    logic [PER_W-1:0] tb_cnt;
    logic [PER_W-1:0] tb_per;
    logic [PER_W-1:0] tb_duty;

    pwm_timebase #(.PER_W(PER_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_in (period_in),
        .duty_in   (duty_in),
        .raw       (raw),
        .cnt       (tb_cnt),
        .per_sh    (tb_per),
        .duty_sh   (tb_duty)
    );

    pwm_deadband #(.DEAD_W(DEAD_W)) u_db (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw        (raw),
        .dead_steps (dead_in),
        .lag        (lag),
        .on_hi      (on_hi),
        .on_lo      (on_lo)
    );

    pwm_steer u_st (
        .mode  (pwm_mode_e'(mode_sel)),
        .fwd   (fwd_dir),
        .pol_n (pol_n),
        .mod   (lag),
        .on_hi (on_hi),
        .on_lo (on_lo),
        .out   (pwm_out)
    );
endmodule

// File: rtl/pwm_bridge_chk.sv
// Property checker for the bridge PWM generator, bound to the top.
// Assumes outputs are judged after removing the selected polarity.
module pwm_bridge_chk #(
    parameter int PER_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic             fwd_dir,
    input logic [3:0]       pol_n,
    input logic [3:0]       pwm_out,
    input logic [PER_W-1:0] cnt,
    input logic [PER_W-1:0] per_q,
    input logic [PER_W-1:0] duty_q
);
    logic [3:0] act;

    // Active view of the outputs, with the pairwise polarity of quad mode.
    assign act = pwm_out ^ ((mode_sel == 2'd2) ? {pol_n[1], pol_n[0], pol_n[1], pol_n[0]} : pol_n);

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd1) |-> !(act[0] && act[1]));

    p_single_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd0) |-> (act[3:1] == 3'b000));

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) || (cnt < per_q));

    p_quad_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd2 && fwd_dir) |-> (act[0] && !act[1] && !act[2]));

    p_quad_rev_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd2 && !fwd_dir) |-> (act[2] && !act[0] && !act[3]));

    p_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd3) |-> (act == 4'b0000));

    p_hold_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> ($stable(per_q) && $stable(duty_q)));
endmodule

bind pwm_bridge_gen pwm_bridge_chk #(.PER_W(PER_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .fwd_dir  (fwd_dir),
    .pol_n    (pol_n),
    .pwm_out  (pwm_out),
    .cnt      (tb_cnt),
    .per_q    (tb_per),
    .duty_q   (tb_duty)
);

// File: tb/sim_pwm_bridge_gen.sv
module sim_pwm_bridge_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       fwd_dir = 1'b0;
    logic [3:0] pol_n = 4'b0000;
    logic [7:0] period_in = 8'd10;
    logic [7:0] duty_in = 8'd0;
    logic [3:0] dead_in = 4'd0;
    logic [3:0] pwm_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_bridge_gen u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .fwd_dir(fwd_dir),
        .pol_n(pol_n), .period_in(period_in), .duty_in(duty_in),
        .dead_in(dead_in), .pwm_out(pwm_out)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic       fwd;
        logic [3:0] pol;
        logic [7:0] per;
        logic [7:0] duty;
        logic [3:0] dead;
        logic [7:0] ea;
        logic [7:0] eb;
        logic [7:0] ec;
        logic [7:0] ed;
    } vec_t;

    // Stimulus and expected active cycles per period for outputs A..D.
    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{2'd0, 1'b0, 4'b0000, 8'd10, 8'd3,  4'd0, 8'd3,  8'd0,  8'd0,  8'd0},
        '{2'd0, 1'b0, 4'b0001, 8'd10, 8'd3,  4'd0, 8'd3,  8'd0,  8'd0,  8'd0},
        '{2'd1, 1'b0, 4'b0000, 8'd20, 8'd8,  4'd1, 8'd4,  8'd8,  8'd0,  8'd0},
        '{2'd1, 1'b0, 4'b0010, 8'd20, 8'd10, 4'd2, 8'd2,  8'd2,  8'd0,  8'd0},
        '{2'd1, 1'b0, 4'b0000, 8'd16, 8'd2,  4'd1, 8'd0,  8'd10, 8'd0,  8'd0},
        '{2'd1, 1'b0, 4'b0000, 8'd12, 8'd0,  4'd1, 8'd0,  8'd12, 8'd0,  8'd0},
        '{2'd1, 1'b0, 4'b0000, 8'd12, 8'd15, 4'd1, 8'd12, 8'd0,  8'd0,  8'd0},
        '{2'd2, 1'b1, 4'b0000, 8'd10, 8'd4,  4'd0, 8'd10, 8'd0,  8'd0,  8'd4},
        '{2'd2, 1'b0, 4'b0011, 8'd10, 8'd6,  4'd0, 8'd0,  8'd6,  8'd10, 8'd0},
        '{2'd3, 1'b0, 4'b0101, 8'd10, 8'd5,  4'd0, 8'd0,  8'd0,  8'd0,  8'd0},
        '{2'd0, 1'b0, 4'b0000, 8'd12, 8'd0,  4'd0, 8'd0,  8'd0,  8'd0,  8'd0},
        '{2'd0, 1'b0, 4'b0000, 8'd12, 8'd12, 4'd0, 8'd12, 8'd0,  8'd0,  8'd0}
    };

    function automatic string req_of(int k);
        case (k)
            0: return "R2";
            1: return "R9";
            2: return "R4";
            3: return "R9";
            4: return "R5";
            5: return "R6";
            6: return "R6";
            7: return "R8";
            8: return "R9";
            9: return "R10";
            default: return "R6";
        endcase
    endfunction

    // Active view of the outputs from the polarity rule (R9).
    function automatic logic [3:0] act_of(logic [3:0] o, logic [1:0] m, logic [3:0] p);
        return o ^ ((m == 2'd2) ? {p[1], p[0], p[1], p[0]} : p);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=done", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic run_row(int k);
        int na, nb, nc, nd, ov, win;
        logic [3:0] a;
        mode_sel  = VT[k].mode;
        fwd_dir   = VT[k].fwd;
        pol_n     = VT[k].pol;
        period_in = VT[k].per;
        duty_in   = VT[k].duty;
        dead_in   = VT[k].dead;
        repeat (100) @(negedge clk);
        na = 0; nb = 0; nc = 0; nd = 0; ov = 0;
        win = 4 * int'(VT[k].per);
        for (int i = 0; i < win; i++) begin
            a = act_of(pwm_out, mode_sel, pol_n);
            na += int'(a[0]); nb += int'(a[1]); nc += int'(a[2]); nd += int'(a[3]);
            if (a[0] && a[1]) ov++;
            @(negedge clk);
        end
        chk(req_of(k), $sformatf("row %0d A", k), na, 4 * int'(VT[k].ea));
        chk(req_of(k), $sformatf("row %0d B", k), nb, 4 * int'(VT[k].eb));
        chk(req_of(k), $sformatf("row %0d C", k), nc, 4 * int'(VT[k].ec));
        chk(req_of(k), $sformatf("row %0d D", k), nd, 4 * int'(VT[k].ed));
        if (VT[k].mode == 2'd1) chk("R3", $sformatf("row %0d overlap", k), ov, 0);
    endtask

    task automatic run_len(input bit lvl, output int n);
        n = 0;
        while (pwm_out[0] == lvl) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int g, h, l;
        // R1: reset state.
        repeat (4) @(negedge clk);
        chk("R1", "outputs in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset", int'(pwm_out), 0);

        for (int k = 0; k < NV; k++) run_row(k);

        // R4: dead gap on both edges, dual P=20 D=10 dead=2 -> 8 cycles.
        mode_sel = 2'd1; pol_n = 4'b0000; period_in = 8'd20; duty_in = 8'd10; dead_in = 4'd2;
        fwd_dir = 1'b0;
        repeat (100) @(negedge clk);
        while (!pwm_out[0]) @(negedge clk);
        while (pwm_out[0]) @(negedge clk);
        g = 0;
        while (!pwm_out[0] && !pwm_out[1]) begin g++; @(negedge clk); end
        chk("R4", "gap A off to B on", g, 8);
        while (pwm_out[1]) @(negedge clk);
        g = 0;
        while (!pwm_out[0] && !pwm_out[1]) begin g++; @(negedge clk); end
        chk("R4", "gap B off to A on", g, 8);

        // R7: change during a pulse takes effect next period.
        mode_sel = 2'd0; period_in = 8'd10; duty_in = 8'd5; dead_in = 4'd0;
        repeat (100) @(negedge clk);
        while (pwm_out[0]) @(negedge clk);
        while (!pwm_out[0]) @(negedge clk);
        duty_in = 8'd8; period_in = 8'd12;
        run_len(1'b1, h);
        chk("R7", "pulse in progress keeps width", h, 5);
        run_len(1'b0, l);
        chk("R7", "rest of old period", l, 5);
        run_len(1'b1, h);
        chk("R7", "new pulse width", h, 8);
        run_len(1'b0, l);
        chk("R7", "new low time", l, 4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule